// File: doc/BRIEF.md
# Service Watchdog with Selectable Timeout

This block watches software. Once software turns it on, it counts milliseconds. The milliseconds come from a one-microsecond tick input. If software does not service the block before the selected timeout runs out, it drives a reset pulse of fixed length into the processor. It can also raise an interrupt in the same cycle.

Software uses one 16-bit control and status word on a simple bus. The bus has an address match, a write strobe and registered read data. Through this word software can:

- turn the watchdog on;
- lock it permanently on;
- pick one of four timeouts;
- service it.

A sticky cause flag records that a timeout happened. The flag lives through the internal reset, so software can read the cause after it restarts.

The block keeps two resets apart. The external (power-on) reset clears everything. The internal reset clears everything except the cause flag.

Top module: `svc_watchdog`

## Requirements
- R1: After external reset the word reads 0x0000. Bits 15:6 and the service bit (bit 0) always read as 0.
- R2: The timeout select in bits 4:3 gives a limit of BASE_MS << (2*sel) milliseconds: 00=1, 01=4, 10=16, 11=64 with BASE_MS=1. A millisecond is TICKS_PER_MS asserted clocks of `us_tick`. With `us_tick` held high, `wd_rst_o` rises limit*TICKS_PER_MS+1 clocks after the clock edge that takes a write which both enables and services the watchdog.
- R3: Counting happens only while the enable bit (bit 1) or the lock bit (bit 2) is 1. While both are 0 the block never fires, and the counters are held at zero.
- R4: Writing 1 to the lock bit (bit 2) keeps the watchdog running with the enable bit at 0. A later write of 0 to bit 2 does not clear it.
- R5: A write with bit 0 set restarts the count, including the sub-millisecond prescaler. The full timeout is measured again from that write.
- R6: On expiry `wd_rst_o` is high for exactly RST_LEN clocks. `wd_irq_o` (when USE_IRQ=1) is high for one clock, in the same cycle that `wd_rst_o` rises.
- R7: The cause flag (bit 5) sets on expiry and stays set through the internal reset. Writing 1 to it has no effect. Only the external reset clears it.
- R8: The internal reset clears enable, lock, timeout select and the counters. Bus writes made while it is high are ignored.
- R9: While `us_tick` is low, time does not advance and no timeout occurs.
- R10: `bus_rdata` is registered, one clock after the address. It reads 0 when `bus_addr` does not equal REG_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst | input | 1 | External power-on reset, synchronous, active high |
| us_tick | input | 1 | One-clock strobe per microsecond |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| wd_rst_o | output | 1 | Internal processor reset pulse |
| wd_irq_o | output | 1 | One-clock timeout interrupt |

## Verification
The assertions assume that `ext_rst` is high for at least one clock at the start. They also assume that bus writes are single-clock strobes, so a service write cannot overlap the expiry cycle in a way that hides the cause. The stimulus drives every bus cycle and every change of `us_tick` at the falling edge, and it applies the external reset before each scenario. The bench uses a small prescaler (TICKS_PER_MS=3) and a short reset pulse, so every timeout select can be swept and checked against arithmetic cycle counts.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int BIT_SVC  = 0;
  localparam int BIT_EN   = 1;
  localparam int BIT_LOCK = 2;
  localparam int BIT_SEL  = 3;
  localparam int BIT_FLAG = 5;

  typedef struct packed {
    logic       flag;
    logic [1:0] sel;
    logic       lock;
    logic       en;
  } wdg_ctl_t;
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int TICKS_PER_MS = 1000
) (
  input  logic clk,
  input  logic clr,
  input  logic us_tick,
  output logic ms_tick
);
  localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;

  assign ms_tick = us_tick && !clr && (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (clr)
      pre_q <= '0;
    else if (us_tick)
      pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
  end

  assert_pre_bound_R2: assert property (@(posedge clk) disable iff (clr)
    pre_q <= PRE_LAST);
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int BASE_MS = 1
) (
  input  logic       clk,
  input  logic       clr,
  input  logic       ms_tick,
  input  logic [1:0] sel,
  output logic       expire
);
  localparam int CNT_W = $clog2(BASE_MS * 64 + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;
  logic             expire_q;

  assign lim_m1 = (CNT_W'(BASE_MS) << {sel, 1'b0}) - 1'b1;
  assign expire = expire_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (ms_tick) begin
        if (cnt_q == lim_m1) begin
          cnt_q    <= '0;
          expire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_idle_clear_R3: assert property (@(posedge clk)
    clr |=> (cnt_q == '0 && !expire_q));
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              ext_rst,
  input  logic              wd_rst,
  input  logic              expire,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output wdg_ctl_t          ctl,
  output logic              svc,
  output logic [15:0]       bus_rdata
);
  wdg_ctl_t    ctl_q;
  logic        hit;
  logic        wr_ok;
  logic [15:0] word;
  logic        unused_wbits;

  assign hit          = (bus_addr == REG_ADDR);
  assign wr_ok        = hit && bus_wr && !wd_rst && !ext_rst;
  assign svc          = wr_ok && bus_wdata[BIT_SVC];
  assign ctl          = ctl_q;
  assign unused_wbits = ^{bus_wdata[15:6], bus_wdata[BIT_FLAG]};

  always_comb begin
    word                = '0;
    word[BIT_EN]        = ctl_q.en;
    word[BIT_LOCK]      = ctl_q.lock;
    word[BIT_SEL +: 2]  = ctl_q.sel;
    word[BIT_FLAG]      = ctl_q.flag;
  end

  always_ff @(posedge clk) begin
    if (ext_rst || wd_rst) begin
      ctl_q.en   <= 1'b0;
      ctl_q.lock <= 1'b0;
      ctl_q.sel  <= 2'b00;
    end else if (wr_ok) begin
      ctl_q.en   <= bus_wdata[BIT_EN];
      ctl_q.lock <= ctl_q.lock | bus_wdata[BIT_LOCK];
      ctl_q.sel  <= bus_wdata[BIT_SEL +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (ext_rst)
      ctl_q.flag <= 1'b0;
    else if (expire)
      ctl_q.flag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ext_rst)
      bus_rdata <= '0;
    else
      bus_rdata <= hit ? word : 16'h0000;
  end

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (ext_rst)
    (ctl_q.lock && !wd_rst) |=> ctl_q.lock);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (ext_rst)
    ctl_q.flag |=> ctl_q.flag);
  assert_rdata_reserved_R1: assert property (@(posedge clk) disable iff (ext_rst)
    (bus_rdata[15:6] == '0) && !bus_rdata[BIT_SVC]);
  assert_hold_in_reset_R8: assert property (@(posedge clk) disable iff (ext_rst)
    wd_rst |=> (!ctl_q.en && !ctl_q.lock && ctl_q.sel == 2'b00));
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int RST_LEN = 16,
  parameter bit USE_IRQ = 1'b1
) (
  input  logic clk,
  input  logic ext_rst,
  input  logic expire,
  output logic rst_o,
  output logic irq_o
);
  localparam int LEFT_W = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;

  logic [LEFT_W-1:0] left_q;
  logic              rst_q;

  assign rst_o = rst_q;

  always_ff @(posedge clk) begin
    if (ext_rst) begin
      rst_q  <= 1'b0;
      left_q <= '0;
    end else if (expire) begin
      rst_q  <= 1'b1;
      left_q <= LEFT_W'(RST_LEN - 1);
    end else if (rst_q) begin
      if (left_q == '0)
        rst_q <= 1'b0;
      else
        left_q <= left_q - 1'b1;
    end
  end

  generate
    if (USE_IRQ) begin : g_irq
      logic irq_q;
      always_ff @(posedge clk) begin
        if (ext_rst) irq_q <= 1'b0;
        else         irq_q <= expire;
      end
      assign irq_o = irq_q;
    end else begin : g_no_irq
      assign irq_o = 1'b0;
    end
  endgenerate

  assert_irq_with_rst_R6: assert property (@(posedge clk) disable iff (ext_rst)
    irq_o |-> rst_o);
  assert_rst_from_expire_R6: assert property (@(posedge clk) disable iff (ext_rst)
    $rose(rst_o) |-> $past(expire));
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import wdg_pkg::*;
#(
  parameter int                TICKS_PER_MS = 1000,
  parameter int                BASE_MS      = 1,
  parameter int                RST_LEN      = 16,
  parameter bit                USE_IRQ      = 1'b1,
  parameter int                ADDR_W       = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR     = 4'hC
) (
  input  logic              clk,
  input  logic              ext_rst,
  input  logic              us_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              wd_rst_o,
  output logic              wd_irq_o
);
  wdg_ctl_t ctl;
  logic     svc;
  logic     expire;
  logic     ms_tick;
  logic     cnt_clr;

  assign cnt_clr = ext_rst || wd_rst_o || svc || !(ctl.en || ctl.lock);

  wdg_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) ctrl_i (
    .clk(clk), .ext_rst(ext_rst), .wd_rst(wd_rst_o), .expire(expire),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .ctl(ctl), .svc(svc), .bus_rdata(bus_rdata)
  );

  wdg_prescale #(.TICKS_PER_MS(TICKS_PER_MS)) pre_i (
    .clk(clk), .clr(cnt_clr), .us_tick(us_tick), .ms_tick(ms_tick)
  );

  wdg_count #(.BASE_MS(BASE_MS)) cnt_i (
    .clk(clk), .clr(cnt_clr), .ms_tick(ms_tick), .sel(ctl.sel), .expire(expire)
  );

  wdg_pulse #(.RST_LEN(RST_LEN), .USE_IRQ(USE_IRQ)) pulse_i (
    .clk(clk), .ext_rst(ext_rst), .expire(expire),
    .rst_o(wd_rst_o), .irq_o(wd_irq_o)
  );

  assert_flag_on_fire_R7: assert property (@(posedge clk) disable iff (ext_rst)
    $rose(wd_rst_o) |-> ctl.flag);
  assert_quiet_when_off_R3: assert property (@(posedge clk) disable iff (ext_rst)
    (!ctl.en && !ctl.lock && !wd_rst_o) |=> !$rose(wd_rst_o));
endmodule

// File: tb/svc_watchdog_tb_top.sv
`timescale 1ns/1ps
module svc_watchdog_tb_top;
  localparam int TPM   = 3;
  localparam int RLEN  = 8;
  localparam logic [3:0] RA = 4'hC;

  logic        clk = 1'b0;
  logic        ext_rst = 1'b1;
  logic        us_tick = 1'b1;
  logic [3:0]  bus_addr = RA;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        wd_rst_o, wd_irq_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  svc_watchdog #(.TICKS_PER_MS(TPM), .BASE_MS(1), .RST_LEN(RLEN), .USE_IRQ(1'b1),
                 .ADDR_W(4), .REG_ADDR(RA)) dut_i (
    .clk(clk), .ext_rst(ext_rst), .us_tick(us_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_rst_o(wd_rst_o), .wd_irq_o(wd_irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); ext_rst = 1'b1; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    ext_rst = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); bus_addr = RA; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); bus_addr = a; bus_wr = 1'b0;
    @(posedge clk);
    @(negedge clk); v = bus_rdata; bus_addr = RA;
  endtask

  // clocks from the last write edge until wd_rst_o seen high; -1 if not within maxc
  task automatic wait_rst(input int maxc, output int n);
    n = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (wd_rst_o) begin n = i; break; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: bench timed out");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n, len, irq_cnt;

    do_reset();
    rd(RA, v);
    chk("R1 reset value", v, 16'h0000);
    wr(16'h0001);
    rd(RA, v);
    chk("R1 service bit reads 0", v, 16'h0000);

    // R2 / R6 / R7 sweep over every timeout select
    for (int s = 0; s < 4; s++) begin
      do_reset();
      wr(16'(2 | (s << 3) | 1));
      rd(RA, v);
      chk("R2 select readback", v, 2 | (s << 3));
      do_reset();
      wr(16'(2 | (s << 3) | 1));
      wait_rst(300, n);
      chk("R2 timeout cycles", n, (1 << (2 * s)) * TPM + 1);
      chk("R6 irq at rise", wd_irq_o, 1);
      len = 1; irq_cnt = 1;
      while (len < 50) begin
        @(negedge clk);
        if (!wd_rst_o) break;
        len++;
        if (wd_irq_o) irq_cnt++;
      end
      chk("R6 reset pulse length", len, RLEN);
      chk("R6 irq single clock", irq_cnt, 1);
      rd(RA, v);
      chk("R7 R8 flag kept, control cleared", v, 16'h0020);
    end

    // R7 flag write has no effect, then ext reset clears it
    wr(16'h0020);
    rd(RA, v);
    chk("R7 write 1 to flag ignored", v, 16'h0020);
    wr(16'h0000);
    rd(RA, v);
    chk("R7 write 0 does not clear flag", v, 16'h0020);
    rd(4'h3, v);
    chk("R10 other address reads 0", v, 16'h0000);
    do_reset();
    rd(RA, v);
    chk("R7 external reset clears flag", v, 16'h0000);

    // R3 disabled watchdog never fires
    do_reset();
    wr(16'h0019);
    wait_rst(400, n);
    chk("R3 disabled never fires", n, -1);

    // R5 service restarts count (select 01: 4 ms)
    do_reset();
    wr(16'h000B);
    wait_rst(8, n);
    chk("R5 no fire before service", n, -1);
    wr(16'h000B);
    wait_rst(100, n);
    chk("R5 full timeout after service", n, 4 * TPM + 1);

    // R4 lock keeps counting, cannot be cleared
    do_reset();
    wr(16'h0015);
    wr(16'h0010);
    rd(RA, v);
    chk("R4 lock survives write of 0", v, 16'h0014);
    wait_rst(100, n);
    chk("R4 locked watchdog fires", int'(n > 0), 1);
    repeat (RLEN + 2) @(negedge clk);
    rd(RA, v);
    chk("R8 lock cleared by internal reset", v, 16'h0020);

    // R8 writes during the internal reset are ignored
    do_reset();
    wr(16'h0003);
    wait_rst(20, n);
    chk("R8 select 00 fires", n, TPM + 1);
    wr(16'h001E);
    repeat (RLEN) @(negedge clk);
    rd(RA, v);
    chk("R8 write during reset ignored", v, 16'h0020);

    // R9 no time without us_tick
    do_reset();
    @(negedge clk); us_tick = 1'b0;
    wr(16'h0003);
    wait_rst(60, n);
    chk("R9 no tick no timeout", n, -1);
    @(negedge clk); us_tick = 1'b1;
    wait_rst(20, n);
    chk("R9 resumes after tick", int'(n > 0 && n <= TPM + 1), 1);

    // R10 read latency: value appears one clock after address
    do_reset();
    wr(16'h0002);
    @(negedge clk); bus_addr = 4'h0;
    @(posedge clk); @(negedge clk);
    bus_addr = RA;
    chk("R10 non-matching address", bus_rdata, 16'h0000);
    chk("R10 old data before edge", bus_rdata, 16'h0000);
    @(posedge clk); @(negedge clk);
    chk("R10 data one clock after address", bus_rdata, 16'h0002);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule